// File: doc/BRIEF.md
# DMA Controller Host Register Interface

This block is the processor-facing register set of a four-channel DMA controller. It sits on an 8-bit I/O data bus with a 4-bit port address. It holds the configuration that software writes: per-channel start offsets and block lengths, a command byte, per-channel mode fields, mask bits and software requests. It presents those values to the channel engines and to the arbiter. On reads it returns either the engines' live address and remaining count, or a status byte that combines pending requests with terminal-count flags.

Each channel has two 16-bit quantities, and each is reached through one byte-wide port. A single shared byte pointer decides which half of a word the next access touches. The pointer flips on every read or write of any word port. Software first clears it through a dedicated action port, then moves the low byte followed by the high byte. Some ports behave as commands: a write to them acts regardless of the data value. A write to an offset or length port updates the base value. It also sends a one-cycle load strobe so that the owning engine copies the base value into its working register.

Top module: `dma_regfile`

## Requirements
- R1: After `rst_n` is released, all four mask bits read 1, `cmd_reg`, `sw_req`, the terminal-count flags, `load_off`, `load_len` and `chan_clr` are 0, and the byte pointer selects the low byte.
- R2: Ports 0 to 7 are word ports: the offset of channel c is at 2c and its length at 2c+1. A single byte pointer is shared by all eight word ports. It selects the low byte (bits 7:0) when clear and the high byte (bits 15:8) when set, and it toggles on every read or write of any word port.
- R3: Any write to port 12 forces the byte pointer to the low-byte state, whatever the data.
- R4: A write to a word port replaces the selected byte of that channel's base offset or base length. In the following cycle, exactly the matching bit of `load_off` or `load_len` is 1 for one cycle.
- R5: A read of a word port returns the selected byte of the engine's live value, `cur_off` for an offset port and `cur_len` for a length port, for that channel.
- R6: A write to port 10 sets (data bit 2 = 1) or clears (bit 2 = 0) the mask of the channel given by data bits 1:0, and leaves the other masks unchanged.
- R7: A write to port 15 loads all four masks from data bits 3:0, with bit c going to channel c.
- R8: A write to port 11 stores data bits 7:2 as the 6-bit mode of the channel given by data bits 1:0. The mode appears at `mode_reg[6c+5:6c]`.
- R9: A write to port 9 sets (data bit 2 = 1) or clears the software request of the channel given by data bits 1:0.
- R10: A write to port 8 loads `cmd_reg`. A read of port 8 returns the status byte: bit 4+c is `hw_req[c] | sw_req[c]` and bit c is channel c's terminal-count flag.
- R11: A pulse on `tc_hit[c]` sets channel c's terminal-count flag. A status read clears all the flags after the read, except a flag whose `tc_hit` is high in that same cycle, which stays set.
- R12: Any write to port 13 sets all masks, clears `cmd_reg`, the software requests, the terminal-count flags and the byte pointer, and drives `chan_clr` high for the following cycle.
- R13: Any write to port 14 clears all four mask bits, whatever the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 4 | Port address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while `rd_en` is high, otherwise 0 |
| cur_off | input | 64 | Live working offset of each channel, 16 bits per channel |
| cur_len | input | 64 | Live remaining count of each channel, 16 bits per channel |
| hw_req | input | 4 | Hardware request lines, for status |
| tc_hit | input | 4 | Terminal-count pulses from the engines |
| base_off | output | 64 | Programmed start offsets |
| base_len | output | 64 | Programmed block lengths |
| load_off | output | 4 | One-cycle strobe: the engine copies the base offset |
| load_len | output | 4 | One-cycle strobe: the engine copies the base length |
| cmd_reg | output | 8 | Command byte |
| mode_reg | output | 24 | Mode fields, 6 bits per channel |
| mask | output | 4 | Channel mask bits (1 = disabled) |
| sw_req | output | 4 | Software request bits |
| chan_clr | output | 1 | One-cycle clear to the engines after a master reset |

## Verification
The bench builds the block at its natural size of four channels with 16-bit words over an 8-bit bus. At that size every channel, every word port, both byte-pointer states and all sixteen master-mask codes can be swept exhaustively. It also steps through every single-mask and request encoding on each channel, and through several mode patterns. The live engine values are driven from arithmetic patterns that differ per channel and per word, so a wrong channel, the wrong word or the wrong byte all produce a visible mismatch. Crossing accesses between channels then exposes a pointer that is not shared.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;
  localparam int DATA_W = 8;
  localparam int WORD_W = 2 * DATA_W;
  localparam int NCH    = 4;
  localparam int CH_W   = $clog2(NCH);
  localparam int MODE_W = DATA_W - CH_W;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    P_CMD    = 4'd8,
    P_REQ    = 4'd9,
    P_SMASK  = 4'd10,
    P_MODE   = 4'd11,
    P_CLRPTR = 4'd12,
    P_MRST   = 4'd13,
    P_MEN    = 4'd14,
    P_MMASK  = 4'd15
  } port_e;

  function automatic logic [DATA_W-1:0] pick_byte(input logic [WORD_W-1:0] w, input logic hi);
    return hi ? w[WORD_W-1:DATA_W] : w[DATA_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] merge_byte(input logic [WORD_W-1:0] w,
                                                   input logic [DATA_W-1:0] b, input logic hi);
    return hi ? {b, w[DATA_W-1:0]} : {w[WORD_W-1:DATA_W], b};
  endfunction

  function automatic logic [DATA_W-1:0] status_byte(input logic [NCH-1:0] pend,
                                                    input logic [NCH-1:0] tc);
    return {pend, tc};
  endfunction
endpackage

// File: rtl/dma_rf_decode.sv
module dma_rf_decode
  import dma_rf_pkg::*;
(
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              word_acc,
  output logic              word_wr,
  output logic [CH_W-1:0]   word_ch,
  output logic              word_is_len,
  output logic              wr_cmd,
  output logic              wr_req,
  output logic              wr_smask,
  output logic              wr_mode,
  output logic              wr_clrptr,
  output logic              wr_mrst,
  output logic              wr_men,
  output logic              wr_mmask,
  output logic              rd_stat
);
  logic is_word;
  assign is_word     = ~addr[ADDR_W-1];
  assign word_ch     = addr[CH_W:1];
  assign word_is_len = addr[0];
  assign word_wr     = wr_en & is_word;
  assign word_acc    = (wr_en | rd_en) & is_word;

  assign wr_cmd    = wr_en & (addr == P_CMD);
  assign wr_req    = wr_en & (addr == P_REQ);
  assign wr_smask  = wr_en & (addr == P_SMASK);
  assign wr_mode   = wr_en & (addr == P_MODE);
  assign wr_clrptr = wr_en & (addr == P_CLRPTR);
  assign wr_mrst   = wr_en & (addr == P_MRST);
  assign wr_men    = wr_en & (addr == P_MEN);
  assign wr_mmask  = wr_en & (addr == P_MMASK);
  assign rd_stat   = rd_en & ~wr_en & (addr == P_CMD);

  always_comb begin
    assert_one_cmd_R12: assert ($onehot0({wr_cmd, wr_req, wr_smask, wr_mode,
                                           wr_clrptr, wr_mrst, wr_men, wr_mmask, word_wr}))
      else $error("decode raised more than one write strobe");
  end
endmodule

// File: rtl/dma_rf_words.sv
module dma_rf_words
  import dma_rf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mrst,
  input  logic                  clrptr,
  input  logic                  word_acc,
  input  logic                  word_wr,
  input  logic [CH_W-1:0]       word_ch,
  input  logic                  word_is_len,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [NCH*WORD_W-1:0] cur_off,
  input  logic [NCH*WORD_W-1:0] cur_len,
  output logic [NCH*WORD_W-1:0] base_off,
  output logic [NCH*WORD_W-1:0] base_len,
  output logic [NCH-1:0]        load_off,
  output logic [NCH-1:0]        load_len,
  output logic [DATA_W-1:0]     word_rdata,
  output logic                  ptr_hi
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ptr_hi <= 1'b0;
    else if (mrst || clrptr)  ptr_hi <= 1'b0;
    else if (word_acc)        ptr_hi <= ~ptr_hi;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit_off, hit_len;
    assign hit_off = word_wr && (word_ch == CH_W'(c)) && !word_is_len;
    assign hit_len = word_wr && (word_ch == CH_W'(c)) &&  word_is_len;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_off[c*WORD_W +: WORD_W] <= '0;
        base_len[c*WORD_W +: WORD_W] <= '0;
        load_off[c] <= 1'b0;
        load_len[c] <= 1'b0;
      end else begin
        load_off[c] <= hit_off;
        load_len[c] <= hit_len;
        if (hit_off) base_off[c*WORD_W +: WORD_W] <= merge_byte(base_off[c*WORD_W +: WORD_W], wdata, ptr_hi);
        if (hit_len) base_len[c*WORD_W +: WORD_W] <= merge_byte(base_len[c*WORD_W +: WORD_W], wdata, ptr_hi);
      end
    end
  end

  logic [WORD_W-1:0] live_word;
  assign live_word  = word_is_len ? cur_len[word_ch*WORD_W +: WORD_W] : cur_off[word_ch*WORD_W +: WORD_W];
  assign word_rdata = pick_byte(live_word, ptr_hi);

  assert_ptr_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (word_acc && !clrptr && !mrst) |=> (ptr_hi != $past(ptr_hi)));
  assert_ptr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clrptr |=> !ptr_hi);
  assert_load_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_off, load_len}));
  assert_load_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !word_wr |=> ({load_off, load_len} == '0));
endmodule

// File: rtl/dma_rf_ctrl.sv
module dma_rf_ctrl
  import dma_rf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_cmd,
  input  logic                  wr_req,
  input  logic                  wr_smask,
  input  logic                  wr_mode,
  input  logic                  wr_mrst,
  input  logic                  wr_men,
  input  logic                  wr_mmask,
  input  logic                  rd_stat,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [NCH-1:0]        tc_hit,
  output logic [DATA_W-1:0]     cmd_reg,
  output logic [NCH*MODE_W-1:0] mode_reg,
  output logic [NCH-1:0]        mask,
  output logic [NCH-1:0]        sw_req,
  output logic [NCH-1:0]        tc_flags,
  output logic                  chan_clr
);
  logic [CH_W-1:0] sel_ch;
  logic            sel_bit;
  assign sel_ch  = wdata[CH_W-1:0];
  assign sel_bit = wdata[CH_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_reg  <= '0;
      chan_clr <= 1'b0;
    end else begin
      chan_clr <= wr_mrst;
      if (wr_mrst)     cmd_reg <= '0;
      else if (wr_cmd) cmd_reg <= wdata;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic pick;
    assign pick = (sel_ch == CH_W'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask[c]     <= 1'b1;
        sw_req[c]   <= 1'b0;
        tc_flags[c] <= 1'b0;
        mode_reg[c*MODE_W +: MODE_W] <= '0;
      end else begin
        if (wr_mrst)                mask[c] <= 1'b1;
        else if (wr_men)            mask[c] <= 1'b0;
        else if (wr_mmask)          mask[c] <= wdata[c];
        else if (wr_smask && pick)  mask[c] <= sel_bit;

        if (wr_mrst)               sw_req[c] <= 1'b0;
        else if (wr_req && pick)   sw_req[c] <= sel_bit;

        if (wr_mrst)        tc_flags[c] <= 1'b0;
        else if (tc_hit[c]) tc_flags[c] <= 1'b1;
        else if (rd_stat)   tc_flags[c] <= 1'b0;

        if (wr_mode && pick) mode_reg[c*MODE_W +: MODE_W] <= wdata[DATA_W-1:CH_W];
      end
    end
  end

  assert_mrst_state_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mrst |=> (&mask && sw_req == '0 && tc_flags == '0 && cmd_reg == '0 && chan_clr));
  assert_men_unmask_R13: assert property (@(posedge clk) disable iff (!rst_n)
    wr_men |=> (mask == '0));
  assert_tc_read_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && tc_hit == '0) |=> (tc_flags == '0));
  assert_tc_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_mrst && tc_hit != '0) |=> ((tc_flags & $past(tc_hit)) == $past(tc_hit)));
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_rf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata,
  input  logic [NCH*WORD_W-1:0] cur_off,
  input  logic [NCH*WORD_W-1:0] cur_len,
  input  logic [NCH-1:0]        hw_req,
  input  logic [NCH-1:0]        tc_hit,
  output logic [NCH*WORD_W-1:0] base_off,
  output logic [NCH*WORD_W-1:0] base_len,
  output logic [NCH-1:0]        load_off,
  output logic [NCH-1:0]        load_len,
  output logic [DATA_W-1:0]     cmd_reg,
  output logic [NCH*MODE_W-1:0] mode_reg,
  output logic [NCH-1:0]        mask,
  output logic [NCH-1:0]        sw_req,
  output logic                  chan_clr
);
  logic              word_acc, word_wr, word_is_len;
  logic [CH_W-1:0]   word_ch;
  logic              wr_cmd, wr_req, wr_smask, wr_mode, wr_clrptr, wr_mrst, wr_men, wr_mmask, rd_stat;
  logic [DATA_W-1:0] word_rdata;
  logic              ptr_hi;
  logic [NCH-1:0]    tc_flags;

  dma_rf_decode u_dec (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .word_acc(word_acc), .word_wr(word_wr), .word_ch(word_ch), .word_is_len(word_is_len),
    .wr_cmd(wr_cmd), .wr_req(wr_req), .wr_smask(wr_smask), .wr_mode(wr_mode),
    .wr_clrptr(wr_clrptr), .wr_mrst(wr_mrst), .wr_men(wr_men), .wr_mmask(wr_mmask),
    .rd_stat(rd_stat)
  );

  dma_rf_words u_words (
    .clk(clk), .rst_n(rst_n), .mrst(wr_mrst), .clrptr(wr_clrptr),
    .word_acc(word_acc), .word_wr(word_wr), .word_ch(word_ch), .word_is_len(word_is_len),
    .wdata(wdata), .cur_off(cur_off), .cur_len(cur_len),
    .base_off(base_off), .base_len(base_len), .load_off(load_off), .load_len(load_len),
    .word_rdata(word_rdata), .ptr_hi(ptr_hi)
  );

  dma_rf_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wr_req(wr_req), .wr_smask(wr_smask),
    .wr_mode(wr_mode), .wr_mrst(wr_mrst), .wr_men(wr_men), .wr_mmask(wr_mmask),
    .rd_stat(rd_stat), .wdata(wdata), .tc_hit(tc_hit),
    .cmd_reg(cmd_reg), .mode_reg(mode_reg), .mask(mask), .sw_req(sw_req),
    .tc_flags(tc_flags), .chan_clr(chan_clr)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (!addr[ADDR_W-1])     rdata = word_rdata;
      else if (addr == P_CMD)  rdata = status_byte(hw_req | sw_req, tc_flags);
    end
  end

  assert_rdata_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == '0));
  assert_clr_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    chan_clr |=> !chan_clr || $past(wr_mrst));
endmodule

// File: tb/dma_regfile_tb.sv
module dma_regfile_tb;
  localparam int TCLK = 10;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [63:0] cur_off, cur_len;
  logic [3:0]  hw_req = '0, tc_hit = '0;
  logic [63:0] base_off, base_len;
  logic [3:0]  load_off, load_len, mask, sw_req;
  logic [7:0]  cmd_reg;
  logic [23:0] mode_reg;
  logic        chan_clr;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(TCLK/2) clk = ~clk;

  dma_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cur_off(cur_off), .cur_len(cur_len), .hw_req(hw_req), .tc_hit(tc_hit),
    .base_off(base_off), .base_len(base_len), .load_off(load_off), .load_len(load_len),
    .cmd_reg(cmd_reg), .mode_reg(mode_reg), .mask(mask), .sw_req(sw_req), .chan_clr(chan_clr)
  );

  function automatic logic [15:0] live_off(int c); return 16'h1234 + 16'h2101 * c[15:0]; endfunction
  function automatic logic [15:0] live_len(int c); return 16'hF0E1 - 16'h0F13 * c[15:0]; endfunction
  function automatic logic [15:0] prog_val(int c, int isl); return 16'h5A00 + 16'h0137 * c[15:0] + (isl ? 16'h8081 : 16'h0); endfunction

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      cur_off[c*16 +: 16] = live_off(c);
      cur_len[c*16 +: 16] = live_len(c);
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  initial begin
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mask", mask, 4'hF);
    chk("R1 cmd", cmd_reg, 0);
    chk("R1 swreq", sw_req, 0);
    chk("R1 load", {load_off, load_len}, 0);
    chk("R1 clr", chan_clr, 0);
    rd(4'd8, b); chk("R1 status", b, 0);
    rd(4'd0, b); chk("R1 ptr low", b, live_off(0) & 16'hFF);

    // R2 R4 program every word of every channel
    wr(4'd12, 8'h00);
    for (int c = 0; c < NC; c++) begin
      for (int l = 0; l < 2; l++) begin
        logic [15:0] v;
        v = prog_val(c, l);
        wr(4'(2*c + l), v[7:0]);
        chk("R4 load lo", l ? load_len : load_off, 1 << c);
        wr(4'(2*c + l), v[15:8]);
        chk("R4 load hi", l ? load_len : load_off, 1 << c);
        chk("R2 base word", l ? base_len[c*16 +: 16] : base_off[c*16 +: 16], v);
        @(negedge clk);
        chk("R4 load once", {load_off, load_len}, 0);
      end
    end
    for (int c = 0; c < NC; c++) begin
      chk("R4 keep off", base_off[c*16 +: 16], prog_val(c, 0));
      chk("R4 keep len", base_len[c*16 +: 16], prog_val(c, 1));
    end

    // R5 live reads
    for (int c = 0; c < NC; c++) begin
      logic [15:0] o, n;
      o = live_off(c); n = live_len(c);
      wr(4'd12, 8'hA5);
      rd(4'(2*c), b);   chk("R5 off lo", b, o[7:0]);
      rd(4'(2*c), b);   chk("R5 off hi", b, o[15:8]);
      rd(4'(2*c+1), b); chk("R5 len lo", b, n[7:0]);
      rd(4'(2*c+1), b); chk("R5 len hi", b, n[15:8]);
    end

    // R2 pointer shared across ports and read/write
    begin
      logic [15:0] n;
      n = live_len(1);
      wr(4'd12, 8'h00);
      wr(4'd0, 8'h77);
      rd(4'd3, b); chk("R2 shared ptr", b, n[15:8]);
    end

    // R3 clear with arbitrary data
    for (int d = 0; d < 256; d += 51) begin
      logic [15:0] o;
      o = live_off(2);
      wr(4'd12, 8'h00);
      rd(4'd4, b);
      wr(4'd12, 8'(d));
      rd(4'd4, b); chk("R3 clear ptr", b, o[7:0]);
    end

    // R13 / R6 single mask sweep
    for (int c = 0; c < NC; c++) begin
      wr(4'd14, 8'h3C);
      chk("R13 unmask", mask, 0);
      wr(4'd10, 8'(4 | c)); chk("R6 set", mask, 1 << c);
      wr(4'd15, 8'h0F);
      wr(4'd10, 8'(c)); chk("R6 clear", mask, 4'hF & ~(1 << c));
    end

    // R7 master mask all codes
    for (int v = 0; v < 16; v++) begin
      wr(4'd15, 8'(8'hF0 | v)); chk("R7 mmask", mask, v);
    end

    // R8 mode fields
    for (int c = 0; c < NC; c++) begin
      for (int p = 0; p < 3; p++) begin
        logic [5:0] m;
        m = 6'(7 * c + 21 * p + 1);
        wr(4'd11, {m, 2'(c)});
        chk("R8 mode", mode_reg[c*6 +: 6], m);
      end
    end

    // R9 R10 requests and status
    hw_req = 4'b0100;
    for (int c = 0; c < NC; c++) begin
      wr(4'd9, 8'(4 | c));
      chk("R9 set", sw_req[c], 1);
    end
    rd(4'd8, b); chk("R10 pend all", b, 8'hF0);
    wr(4'd9, 8'd1); wr(4'd9, 8'd2);
    chk("R9 clear", sw_req, 4'b1001);
    rd(4'd8, b); chk("R10 pend mix", b, 8'hD0);
    hw_req = 4'b0000;
    wr(4'd8, 8'hC3); chk("R10 cmd", cmd_reg, 8'hC3);

    // R11 terminal count
    @(negedge clk); tc_hit = 4'b0110;
    @(negedge clk); tc_hit = 4'b0000;
    rd(4'd8, b); chk("R11 tc set", b, 8'h96);
    rd(4'd8, b); chk("R11 tc clear", b, 8'h90);
    @(negedge clk); rd_en = 1'b1; addr = 4'd8; tc_hit = 4'b1000;
    @(negedge clk); rd_en = 1'b0; tc_hit = 4'b0000;
    rd(4'd8, b); chk("R11 set wins", b, 8'h98);

    // R12 master reset
    wr(4'd14, 8'h00);
    @(negedge clk); tc_hit = 4'b0001;
    @(negedge clk); tc_hit = 4'b0000;
    rd(4'd1, b);
    @(negedge clk); wr_en = 1'b1; addr = 4'd13; wdata = 8'h5E;
    @(negedge clk); wr_en = 1'b0;
    chk("R12 clr pulse", chan_clr, 1);
    chk("R12 masks", mask, 4'hF);
    chk("R12 cmd", cmd_reg, 0);
    chk("R12 swreq", sw_req, 0);
    @(negedge clk);
    chk("R12 clr once", chan_clr, 0);
    rd(4'd8, b); chk("R12 status", b, 0);
    begin
      logic [15:0] o;
      o = live_off(3);
      rd(4'd6, b); chk("R12 ptr", b, o[7:0]);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule